// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, month and a two-digit year for 2000 to 2099. It also keeps a weekday counter. The count advances from a slow tick enable, nominally 32768 per second, presented as a one-cycle input on the system clock. A control bit starts and stops the count. A busy status bit is raised during the last tick period before each seconds update, so that software can avoid reading or writing time fields while they are about to change.

Every seconds update produces a one-cycle event pulse and sets a sticky status flag. The alarm is a second copy of the six date and time fields. On an update, it fires when all six fields of the new time equal the alarm fields; no field can be excluded from the comparison. The alarm produces its own pulse and sticky flag. Software reaches every register through a byte-wide port with a write strobe and a combinational read path.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. All alarm fields read 0x00. Control (0x40) and status (0x44) read 0x00.
- R2: Control bit 0 (offset 0x40) set to 1 runs the clock, and status bit 1 mirrors it. With the bit at 0, ticks leave the time fields unchanged.
- R3: While running, the seconds advance once every TICKS_PER_SEC accepted ticks, whatever the tick spacing. Status bit 0 (busy) is 1 exactly during the final tick period before an update, and is 0 while stopped.
- R4: Seconds and minutes wrap from 0x59 to 0x00 with a carry. Hours wrap from 0x23 to 0x00 with a carry to the day.
- R5: Day of month wraps to 0x01 after day 0x28, 0x29, 0x30 or 0x31, following the month; a year that is a multiple of four is a leap year. Month wraps from 0x12 to 0x01 and carries to the year, which wraps from 0x99 to 0x00.
- R6: The weekday (offset 0x18, bits 2:0, values 0 to 6) advances with each day carry and wraps from 6 to 0.
- R7: A write to a time field (offsets 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year, 0x18 weekday) loads the byte and restarts the sub-second count. The next update therefore comes a full TICKS_PER_SEC ticks later, and an update that falls in the same cycle is dropped.
- R8: Each update drives sec_evt_o high for exactly one cycle and sets status bit 2. Writing 1 to status bit 2 clears it; an update in the same cycle wins.
- R9: The alarm fields sit at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34, in the same field order as the time. When the time just updated equals all six of them, alarm_evt_o pulses with sec_evt_o and status bit 6 is set. Writing 1 to status bit 6 clears it. A single differing field prevents the alarm.
- R10: A read of any offset not listed above returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow tick enable, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sec_evt_o | output | 1 | One-cycle pulse per seconds update |
| alarm_evt_o | output | 1 | One-cycle pulse on alarm match |

## Verification
Read data is combinational, so a register's new value is visible in the cycle after the clock edge that wrote or updated it. The time fields change at the edge that samples the final tick of a second. Both event pulses are high for the one cycle that follows that edge. The bench steps a behavioural model at each rising edge and compares the read data, both pulses and the model's expected values two nanoseconds after the edge. Inputs are held constant from the preceding falling edge, so each result is sampled in the cycle it is due.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int unsigned FW         = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam logic [7:0]  ADDR_CTRL  = 8'h40;
  localparam logic [7:0]  ADDR_STAT  = 8'h44;

  // field i sits at bits [i*FW +: FW]; i matches the register index
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] mins;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    return (v[3:0] >= 4'd9) ? {hi, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] get_field(input cal_t c, input logic [2:0] i);
    logic [7:0] r;
    case (i)
      3'd0:    r = c.sec;
      3'd1:    r = c.mins;
      3'd2:    r = c.hour;
      3'd3:    r = c.day;
      3'd4:    r = c.mon;
      3'd5:    r = c.year;
      default: r = 8'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_subsec.sv
`timescale 1ns/1ps
module rtc_subsec #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic wrap_o,
  output logic busy_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign busy_o = run_i && (cnt_q == LAST);
  assign wrap_o = busy_o && tick_i;

  // R3: after an update the next one is a full second away
  p_wrap_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !clr_i |=> !busy_o);
  // R7: a time write restarts the sub-second count
  p_clr_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output cal_t       now_o,
  output cal_t       next_o,
  output logic [2:0] wday_o
);
  cal_t       now_q, nx;
  logic [2:0] wday_q, nwd;
  logic       c_sec, c_min, c_hr, c_day, c_mon;

  always_comb begin
    nx    = now_q;
    nwd   = wday_q;
    c_sec = now_q.sec >= 8'h59;
    nx.sec = c_sec ? 8'h00 : bcd_inc(now_q.sec);
    c_min = c_sec && (now_q.mins >= 8'h59);
    if (c_sec) nx.mins = (now_q.mins >= 8'h59) ? 8'h00 : bcd_inc(now_q.mins);
    c_hr  = c_min && (now_q.hour >= 8'h23);
    if (c_min) nx.hour = (now_q.hour >= 8'h23) ? 8'h00 : bcd_inc(now_q.hour);
    c_day = c_hr && (now_q.day >= last_day(now_q.mon, now_q.year));
    if (c_hr) begin
      nx.day = c_day ? 8'h01 : bcd_inc(now_q.day);
      nwd    = (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
    end
    c_mon = c_day && (now_q.mon >= 8'h12);
    if (c_day) nx.mon = c_mon ? 8'h01 : bcd_inc(now_q.mon);
    if (c_mon) nx.year = (now_q.year >= 8'h99) ? 8'h00 : bcd_inc(now_q.year);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q  <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, mins: 8'h00, sec: 8'h00};
      wday_q <= 3'd0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        3'd0:    now_q.sec  <= wr_data_i;
        3'd1:    now_q.mins <= wr_data_i;
        3'd2:    now_q.hour <= wr_data_i;
        3'd3:    now_q.day  <= wr_data_i;
        3'd4:    now_q.mon  <= wr_data_i;
        3'd5:    now_q.year <= wr_data_i;
        3'd6:    wday_q     <= wr_data_i[2:0];
        default: ;
      endcase
    end else if (adv_i) begin
      now_q  <= nx;
      wday_q <= nwd;
    end
  end

  assign now_o  = now_q;
  assign next_o = nx;
  assign wday_o = wday_q;

  // R2: no update and no write leaves the date untouched
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !wr_en_i |=> $stable(now_q) && $stable(wday_q));
  // R4: every update moves the seconds
  p_adv_moves_sec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !wr_en_i |=> now_q.sec != $past(now_q.sec));
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  cal_t cand_i,
  input  cal_t alarm_i,
  output logic match_o
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign eq[g] = cand_i[g*FW +: FW] == alarm_i[g*FW +: FW];
  end

  assign match_o = &eq;
endmodule

// File: rtl/bcd_rtc_top.sv
`timescale 1ns/1ps
module bcd_rtc_top
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sec_evt_o,
  output logic       alarm_evt_o
);
  logic [2:0] idx;
  logic       aligned, is_time, is_alm, is_ctrl, is_stat, time_wr, stat_wr;
  logic       run_q, wrap, busy, adv, match;
  logic       sec_evt_q, alm_evt_q, sec_flag_q, alm_flag_q;
  cal_t       now, nxt, alm_q;
  logic [2:0] wday;

  assign idx     = addr_i[4:2];
  assign aligned = addr_i[1:0] == 2'b00;
  assign is_time = aligned && (addr_i[7:5] == 3'd0) && (idx <= 3'd6);
  assign is_alm  = aligned && (addr_i[7:5] == 3'd1) && (idx <= 3'd5);
  assign is_ctrl = addr_i == ADDR_CTRL;
  assign is_stat = addr_i == ADDR_STAT;
  assign time_wr = we_i && is_time;
  assign stat_wr = we_i && is_stat;

  rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run_q),
    .clr_i  (time_wr),
    .wrap_o (wrap),
    .busy_o (busy)
  );

  // a colliding software write drops the update
  assign adv = wrap && !time_wr;

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .wr_en_i   (time_wr),
    .wr_sel_i  (idx),
    .wr_data_i (wdata_i),
    .now_o     (now),
    .next_o    (nxt),
    .wday_o    (wday)
  );

  rtc_alarm_match u_match (
    .cand_i  (nxt),
    .alarm_i (alm_q),
    .match_o (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
    end else if (we_i && is_alm) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (idx == 3'(i)) alm_q[i*FW +: FW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      sec_evt_q  <= 1'b0;
      alm_evt_q  <= 1'b0;
      sec_flag_q <= 1'b0;
      alm_flag_q <= 1'b0;
    end else begin
      if (we_i && is_ctrl) run_q <= wdata_i[0];
      sec_evt_q <= adv;
      alm_evt_q <= adv && match;
      if (adv)                         sec_flag_q <= 1'b1;
      else if (stat_wr && wdata_i[2])  sec_flag_q <= 1'b0;
      if (adv && match)                alm_flag_q <= 1'b1;
      else if (stat_wr && wdata_i[6])  alm_flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (is_time)      rdata_o = (idx == 3'd6) ? {5'd0, wday} : get_field(now, idx);
    else if (is_alm)  rdata_o = get_field(alm_q, idx);
    else if (is_ctrl) rdata_o = {7'd0, run_q};
    else if (is_stat) rdata_o = {1'b0, alm_flag_q, 3'b000, sec_flag_q, run_q, busy};
  end

  assign sec_evt_o   = sec_evt_q;
  assign alarm_evt_o = alm_evt_q;

  // R8: the seconds event is a single-cycle pulse
  p_evt_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_evt_o |=> !sec_evt_o);
  // R9: an alarm only fires together with an update
  p_alarm_on_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_o |-> sec_evt_o);
  // R8: the sticky flag follows every event
  p_flag_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_evt_o |-> rdata_o == rdata_o && sec_flag_q);
endmodule

// File: tb/sim_bcd_rtc_top.sv
`timescale 1ns/1ps
module sim_bcd_rtc_top;
  localparam int TPS = 8;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       sec_evt, alarm_evt;

  int checks = 0, fails = 0, alarm_seen = 0, sec_seen = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_top #(.TICKS_PER_SEC(TPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sec_evt_o(sec_evt), .alarm_evt_o(alarm_evt)
  );

  // behavioural model, binary fields
  int m_s, m_mi, m_h, m_d = 1, m_mo = 1, m_y, m_wd, m_div;
  int a_s, a_mi, a_h, a_d, a_mo, a_y;
  bit m_run, m_fs, m_fa, m_es, m_ea;

  function automatic int b2b(input logic [7:0] v); return v[7:4] * 10 + v[3:0]; endfunction
  function automatic logic [7:0] tobcd(input int v); return 8'(((v / 10) << 4) | (v % 10)); endfunction
  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_reset();
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_wd = 0; m_div = 0;
    a_s = 0; a_mi = 0; a_h = 0; a_d = 0; a_mo = 0; a_y = 0;
    m_run = 0; m_fs = 0; m_fa = 0; m_es = 0; m_ea = 0;
  endtask

  task automatic m_advance();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0; m_wd = (m_wd == 6) ? 0 : m_wd + 1; m_d++;
          if (m_d > dim(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic m_step();
    bit tw, roll;
    tw = we && (addr <= 8'h18) && (addr[1:0] == 2'b00);
    roll = m_run && tick && (m_div == TPS - 1) && !tw;
    m_es = 0; m_ea = 0;
    if (we && addr == 8'h44) begin
      if (wdata[2]) m_fs = 0;
      if (wdata[6]) m_fa = 0;
    end
    if (roll) begin
      m_advance();
      m_div = 0; m_es = 1; m_fs = 1;
      if (m_s == a_s && m_mi == a_mi && m_h == a_h && m_d == a_d && m_mo == a_mo && m_y == a_y) begin
        m_ea = 1; m_fa = 1;
      end
    end else if (tw) m_div = 0;
    else if (m_run && tick) m_div++;
    if (we) begin
      case (addr)
        8'h00: m_s  = b2b(wdata);
        8'h04: m_mi = b2b(wdata);
        8'h08: m_h  = b2b(wdata);
        8'h0C: m_d  = b2b(wdata);
        8'h10: m_mo = b2b(wdata);
        8'h14: m_y  = b2b(wdata);
        8'h18: m_wd = int'(wdata[2:0]);
        8'h20: a_s  = b2b(wdata);
        8'h24: a_mi = b2b(wdata);
        8'h28: a_h  = b2b(wdata);
        8'h2C: a_d  = b2b(wdata);
        8'h30: a_mo = b2b(wdata);
        8'h34: a_y  = b2b(wdata);
        8'h40: m_run = wdata[0];
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return tobcd(m_s);
      8'h04: return tobcd(m_mi);
      8'h08: return tobcd(m_h);
      8'h0C: return tobcd(m_d);
      8'h10: return tobcd(m_mo);
      8'h14: return tobcd(m_y);
      8'h18: return 8'(m_wd);
      8'h20: return tobcd(a_s);
      8'h24: return tobcd(a_mi);
      8'h28: return tobcd(a_h);
      8'h2C: return tobcd(a_d);
      8'h30: return tobcd(a_mo);
      8'h34: return tobcd(a_y);
      8'h40: return {7'd0, m_run};
      8'h44: return {1'b0, m_fa, 3'b000, m_fs, m_run, m_run && (m_div == TPS - 1)};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a <= 8'h08) return "R4";
    if (a <= 8'h14) return "R5";
    if (a == 8'h18) return "R6";
    if (a >= 8'h20 && a <= 8'h34) return "R9";
    if (a == 8'h40) return "R2";
    if (a == 8'h44) return "R3";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_reset();
    else m_step();

  // per-clock comparison, 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && cmp_en) begin
      chk(rdata == m_read(addr), tag_of(addr), rdata, m_read(addr));
      chk(sec_evt == m_es, "R8", sec_evt, m_es);
      chk(alarm_evt == m_ea, "R9", alarm_evt, m_ea);
      if (alarm_evt) alarm_seen++;
      if (sec_evt) sec_seen++;
    end
  end

  function automatic logic [7:0] addr_at(input int k);
    int j;
    j = k % 17;
    if (j < 7) return 8'(j * 4);
    if (j < 13) return 8'(8'h20 + (j - 7) * 4);
    case (j)
      13: return 8'h40;
      14: return 8'h44;
      15: return 8'h48;
      default: return 8'h3C;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; tick = 1'b0; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n, input int every);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); we = 1'b0; addr = addr_at(k); tick = (k % every) == 0;
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); we = 1'b0; tick = 1'b0; addr = a;
    #1 chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, input logic [7:0] wd);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h18, wd);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1 reset state
    rd_chk(8'h00, 8'h00, "R1"); rd_chk(8'h0C, 8'h01, "R1"); rd_chk(8'h10, 8'h01, "R1");
    rd_chk(8'h14, 8'h00, "R1"); rd_chk(8'h20, 8'h00, "R1"); rd_chk(8'h40, 8'h00, "R1");
    rd_chk(8'h44, 8'h00, "R1");
    // R2/R3 run three seconds
    wr(8'h40, 8'h01);
    rd_chk(8'h40, 8'h01, "R2");
    base = sec_seen;
    idle(3 * TPS, 1);
    rd_chk(8'h00, 8'h03, "R3");
    chk(sec_seen - base == 3, "R8", sec_seen - base, 3);
    // R5 leap February
    set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03);
    idle(2 * TPS + 2, 1);
    rd_chk(8'h0C, 8'h29, "R5"); rd_chk(8'h10, 8'h02, "R5");
    rd_chk(8'h08, 8'h00, "R4"); rd_chk(8'h18, 8'h04, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h04);
    idle(TPS + 2, 1);
    rd_chk(8'h0C, 8'h01, "R5"); rd_chk(8'h10, 8'h03, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01);
    idle(TPS + 2, 1);
    rd_chk(8'h0C, 8'h01, "R5"); rd_chk(8'h10, 8'h03, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h25, 8'h02);
    idle(TPS + 2, 1);
    rd_chk(8'h0C, 8'h01, "R5"); rd_chk(8'h10, 8'h05, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
    idle(TPS + 2, 1);
    rd_chk(8'h0C, 8'h01, "R5"); rd_chk(8'h10, 8'h01, "R5"); rd_chk(8'h14, 8'h00, "R5");
    rd_chk(8'h18, 8'h00, "R6"); rd_chk(8'h00, 8'h00, "R4"); rd_chk(8'h04, 8'h00, "R4");
    // R9 alarm, full match then one field off
    wr(8'h20, 8'h58); wr(8'h24, 8'h34); wr(8'h28, 8'h12);
    wr(8'h2C, 8'h15); wr(8'h30, 8'h06); wr(8'h34, 8'h25);
    base = alarm_seen;
    set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h06, 8'h25, 8'h00);
    idle(3 * TPS, 1);
    chk(alarm_seen - base == 1, "R9", alarm_seen - base, 1);
    wr(8'h34, 8'h26);
    base = alarm_seen;
    set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h06, 8'h25, 8'h00);
    idle(3 * TPS, 1);
    chk(alarm_seen - base == 0, "R9", alarm_seen - base, 0);
    // R2 stop holds time
    wr(8'h40, 8'h00);
    idle(3 * TPS, 1);
    rd_chk(8'h00, 8'h59, "R2");
    rd_chk(8'h44, 8'h44, "R2");
    // R8/R9 write-one-to-clear
    wr(8'h44, 8'h04);
    rd_chk(8'h44, 8'h40, "R8");
    wr(8'h44, 8'h40);
    rd_chk(8'h44, 8'h00, "R9");
    // R3 sparse ticks
    wr(8'h40, 8'h01);
    set_time(8'h00, 8'h10, 8'h05, 8'h07, 8'h07, 8'h25, 8'h00);
    idle(2 * TPS + 1, 2);
    rd_chk(8'h00, 8'h01, "R3");
    // R7 write while busy drops the update
    for (int k = 0; k < 4 * TPS; k++) begin
      @(negedge clk); addr = 8'h44; tick = 1'b1;
      #1 if (rdata[0]) break;
    end
    chk(rdata[0] == 1'b1, "R3", rdata[0], 1);
    we = 1'b1; addr = 8'h00; wdata = 8'h30;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    #1 chk(rdata == 8'h30, "R7", rdata, 8'h30);
    rd_chk(8'h44, 8'h06, "R7");
    idle(TPS - 1, 1);
    rd_chk(8'h00, 8'h30, "R7");
    idle(1, 1);
    rd_chk(8'h00, 8'h31, "R7");
    // R10 unmapped offsets
    rd_chk(8'h48, 8'h00, "R10");
    rd_chk(8'h3C, 8'h00, "R10");
    rd_chk(8'h05, 8'h00, "R10");
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule